// File: doc/BRIEF.md
# Enhanced Feature Control with Special-Character Detect

This block keeps an 8-bit enhanced-feature control word for a serial receiver/transmitter channel. Bit 4 of the word is a write-unlock. While it is clear, the upper fields of three neighbouring control registers (interrupt-enable bits 7:4, FIFO-control bits 5:4 and modem-control bits 7:5) cannot change. The block sits in the write path to those registers. It takes each write request and the register's present contents, and passes on a write in which the locked fields keep their old values. Bits 3:0 hold the software flow-control mode selection. This block only stores them.

Bit 5 enables special-character detection on the receive side. Each valid received byte goes to the receive FIFO one cycle later. When detection is on, the block also compares the byte against a programmable 8-bit compare value. On a full match it sets a sticky flag, which feeds the "special character seen" bit of the interrupt identification byte. The matching byte is still stored. The flag clears when the interrupt identification byte is read.

Top module: `enh_feature_ctrl`

## Requirements
- R1: While reset is applied and after it is released, the control word is 0x00, the compare value is 0x00, the special-character flag is 0 and no FIFO push is issued.
- R2: A write to the control word loads all 8 bits. The new value appears on `efr_q` on the clock edge that samples the write.
- R3: While control bit 4 is 0, filtered writes keep the current value in IER bits 7:4, FCR bits 5:4 and MCR bits 7:5, whatever the write data holds.
- R4: While control bit 4 is 1, each filtered write carries the requested data on all 8 bits.
- R5: Bits outside the locked fields always pass through unchanged. Each filtered write strobe equals its request strobe in the same cycle.
- R6: Every cycle with `rx_valid` high gives `fifo_push` high one cycle later, with `fifo_data` equal to the received byte. This holds for matching and non-matching bytes alike.
- R7: With control bit 5 at 1, a valid byte equal to the compare value on all 8 bits sets `spc_flag` one cycle later.
- R8: `spc_flag` is not set when control bit 5 is 0, or when the byte differs from the compare value in any bit.
- R9: `spc_flag` stays set until `iir_rd` is pulsed. A match in the same cycle as a read leaves the flag set.
- R10: A write on the compare port loads the compare value used by later comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| efr_wr | input | 1 | Control word write strobe |
| efr_wdata | input | 8 | Control word write data |
| efr_q | output | 8 | Current control word |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value write data |
| ier_wr_req | input | 1 | Interrupt-enable write request |
| ier_wdata_req | input | 8 | Requested interrupt-enable data |
| ier_cur | input | 8 | Present interrupt-enable contents |
| ier_wr | output | 1 | Filtered interrupt-enable write strobe |
| ier_wdata | output | 8 | Filtered interrupt-enable data |
| fcr_wr_req | input | 1 | FIFO-control write request |
| fcr_wdata_req | input | 8 | Requested FIFO-control data |
| fcr_cur | input | 8 | Present FIFO-control contents |
| fcr_wr | output | 1 | Filtered FIFO-control write strobe |
| fcr_wdata | output | 8 | Filtered FIFO-control data |
| mcr_wr_req | input | 1 | Modem-control write request |
| mcr_wdata_req | input | 8 | Requested modem-control data |
| mcr_cur | input | 8 | Present modem-control contents |
| mcr_wr | output | 1 | Filtered modem-control write strobe |
| mcr_wdata | output | 8 | Filtered modem-control data |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| iir_rd | input | 1 | Interrupt identification read pulse |
| fifo_push | output | 1 | Receive FIFO push |
| fifo_data | output | 8 | Byte pushed into the FIFO |
| spc_flag | output | 1 | Sticky special-character flag |

## Verification
The lock is tested with all-ones data over all-zero contents and with all-zero data over all-ones contents. A wrong field mask would then show up as a stray bit in one of the three registers, and a lock that is bypassed would show up as well. A byte that differs from the compare value in only the top bit must not set the flag, which catches a comparison narrower than 8 bits. A matching byte must still reach the FIFO, which catches a design that drops special characters. A match in the same cycle as an identification read must leave the flag set, which catches a design where the clear wins over a new event. A zero byte is sent with detection on before the compare value is written, to check that the compare value resets to zero.

// File: rtl/efr_pkg.sv
package efr_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned UNLOCK_BIT = 4;
  localparam int unsigned SPC_EN_BIT = 5;
  localparam logic [DW-1:0] IER_LOCK_MASK = 8'hF0;
  localparam logic [DW-1:0] FCR_LOCK_MASK = 8'h30;
  localparam logic [DW-1:0] MCR_LOCK_MASK = 8'hE0;
endpackage

// File: rtl/ctl_reg.sv
module ctl_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr) q_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(wdata)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/wr_guard.sv
module wr_guard #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   MASK = '0
) (
  input  logic         unlock,
  input  logic         wr_req,
  input  logic [W-1:0] wdata_req,
  input  logic [W-1:0] cur,
  output logic         wr,
  output logic [W-1:0] wdata
);
  always_comb begin
    wr = wr_req;
    if (unlock) wdata = wdata_req;
    else        wdata = (wdata_req & ~MASK) | (cur & MASK);
  end

  always_comb begin
    if (!unlock) a_r3_locked: assert ((wdata & MASK) == (cur & MASK));
    a_r5_free_bits: assert ((wdata & ~MASK) == (wdata_req & ~MASK));
  end
endmodule

// File: rtl/spc_detect.sv
module spc_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         det_en,
  input  logic [W-1:0] cmp,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         iir_rd,
  output logic         push,
  output logic [W-1:0] push_data,
  output logic         flag
);
  logic         hit;
  logic         push_nxt;
  logic [W-1:0] push_data_nxt;
  logic         flag_nxt;

  always_comb begin
    hit           = rx_valid && det_en && (rx_data == cmp);
    push_nxt      = rx_valid;
    push_data_nxt = push_data;
    if (rx_valid) push_data_nxt = rx_data;
    flag_nxt = flag;
    if (iir_rd) flag_nxt = 1'b0;
    if (hit)    flag_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push      <= 1'b0;
      push_data <= '0;
      flag      <= 1'b0;
    end else begin
      push      <= push_nxt;
      push_data <= push_data_nxt;
      flag      <= flag_nxt;
    end
  end

  a_r6_push_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (push && push_data == $past(rx_data)));
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !push);
  a_r7_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && det_en && rx_data == cmp) |=> flag);
  a_r8_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(rx_valid && det_en)) |=> !flag);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !iir_rd) |=> flag);
endmodule

// File: rtl/enh_feature_ctrl.sv
module enh_feature_ctrl
  import efr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          efr_wr,
  input  logic [DW-1:0] efr_wdata,
  output logic [DW-1:0] efr_q,
  input  logic          cmp_wr,
  input  logic [DW-1:0] cmp_wdata,
  input  logic          ier_wr_req,
  input  logic [DW-1:0] ier_wdata_req,
  input  logic [DW-1:0] ier_cur,
  output logic          ier_wr,
  output logic [DW-1:0] ier_wdata,
  input  logic          fcr_wr_req,
  input  logic [DW-1:0] fcr_wdata_req,
  input  logic [DW-1:0] fcr_cur,
  output logic          fcr_wr,
  output logic [DW-1:0] fcr_wdata,
  input  logic          mcr_wr_req,
  input  logic [DW-1:0] mcr_wdata_req,
  input  logic [DW-1:0] mcr_cur,
  output logic          mcr_wr,
  output logic [DW-1:0] mcr_wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          iir_rd,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_data,
  output logic          spc_flag
);
  localparam int unsigned NGUARD = 3;

  logic [1:0]    rst_sync;
  logic          rst_s_n;
  logic [DW-1:0] cmp_q;
  logic          unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  ctl_reg #(.W(DW)) u_efr (
    .clk(clk), .rst_n(rst_s_n), .wr(efr_wr), .wdata(efr_wdata), .q(efr_q)
  );

  ctl_reg #(.W(DW)) u_cmp (
    .clk(clk), .rst_n(rst_s_n), .wr(cmp_wr), .wdata(cmp_wdata), .q(cmp_q)
  );

  assign unlock = efr_q[UNLOCK_BIT];

  logic [NGUARD-1:0]         g_req, g_wr;
  logic [NGUARD-1:0][DW-1:0] g_wdreq, g_cur, g_wd;

  assign g_req   = {mcr_wr_req, fcr_wr_req, ier_wr_req};
  assign g_wdreq = {mcr_wdata_req, fcr_wdata_req, ier_wdata_req};
  assign g_cur   = {mcr_cur, fcr_cur, ier_cur};

  localparam logic [NGUARD-1:0][DW-1:0] GMASK = {MCR_LOCK_MASK, FCR_LOCK_MASK, IER_LOCK_MASK};

  for (genvar g = 0; g < NGUARD; g++) begin : g_guard
    wr_guard #(.W(DW), .MASK(GMASK[g])) u_guard (
      .unlock(unlock), .wr_req(g_req[g]), .wdata_req(g_wdreq[g]),
      .cur(g_cur[g]), .wr(g_wr[g]), .wdata(g_wd[g])
    );
  end

  assign {mcr_wr, fcr_wr, ier_wr}          = g_wr;
  assign {mcr_wdata, fcr_wdata, ier_wdata} = g_wd;

  spc_detect #(.W(DW)) u_spc (
    .clk(clk), .rst_n(rst_s_n), .det_en(efr_q[SPC_EN_BIT]), .cmp(cmp_q),
    .rx_valid(rx_valid), .rx_data(rx_data), .iir_rd(iir_rd),
    .push(fifo_push), .push_data(fifo_data), .flag(spc_flag)
  );

  always_comb begin
    a_r5_strobes: assert (ier_wr == ier_wr_req && fcr_wr == fcr_wr_req && mcr_wr == mcr_wr_req);
    if (unlock) a_r4_open: assert (ier_wdata == ier_wdata_req && mcr_wdata == mcr_wdata_req);
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_s_n |=> (efr_q == '0 || !rst_s_n));
endmodule

// File: tb/tb_enh_feature_ctrl.sv
module tb_enh_feature_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic       efr_wr = 0, cmp_wr = 0;
  logic [7:0] efr_wdata = 0, cmp_wdata = 0;
  logic       ier_wr_req = 0, fcr_wr_req = 0, mcr_wr_req = 0;
  logic [7:0] ier_wdata_req = 0, fcr_wdata_req = 0, mcr_wdata_req = 0;
  logic [7:0] ier_cur = 0, fcr_cur = 0, mcr_cur = 0;
  logic       rx_valid = 0, iir_rd = 0;
  logic [7:0] rx_data = 0;
  logic [7:0] efr_q, ier_wdata, fcr_wdata, mcr_wdata, fifo_data;
  logic       ier_wr, fcr_wr, mcr_wr, fifo_push, spc_flag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  enh_feature_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .efr_wr(efr_wr), .efr_wdata(efr_wdata), .efr_q(efr_q),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .ier_wr_req(ier_wr_req), .ier_wdata_req(ier_wdata_req), .ier_cur(ier_cur),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .fcr_wr_req(fcr_wr_req), .fcr_wdata_req(fcr_wdata_req), .fcr_cur(fcr_cur),
    .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .mcr_wr_req(mcr_wr_req), .mcr_wdata_req(mcr_wdata_req), .mcr_cur(mcr_cur),
    .mcr_wr(mcr_wr), .mcr_wdata(mcr_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .iir_rd(iir_rd),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .spc_flag(spc_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_efr(input logic [7:0] v);
    efr_wr = 1; efr_wdata = v; step(); efr_wr = 0;
  endtask

  task automatic write_cmp(input logic [7:0] v);
    cmp_wr = 1; cmp_wdata = v; step(); cmp_wr = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic rd);
    rx_valid = 1; rx_data = b; iir_rd = rd; step();
    rx_valid = 0; iir_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 efr_q", efr_q, 8'h00);
    chk("R1 spc_flag", spc_flag, 0);
    chk("R1 fifo_push", fifo_push, 0);
    write_efr(8'h20);
    send_byte(8'h00, 0);
    chk("R10 reset compare matches 0x00", spc_flag, 1);
    iir_rd = 1; step(); iir_rd = 0;
    write_efr(8'h00);
  endtask

  task automatic t_efr_write();
    write_efr(8'hA5);
    chk("R2 efr load A5", efr_q, 8'hA5);
    step();
    chk("R2 efr hold", efr_q, 8'hA5);
    write_efr(8'h0F);
    chk("R2 efr load 0F", efr_q, 8'h0F);
    write_efr(8'h00);
  endtask

  task automatic t_lock();
    ier_wr_req = 1; fcr_wr_req = 1; mcr_wr_req = 1;
    ier_wdata_req = 8'hFF; fcr_wdata_req = 8'hFF; mcr_wdata_req = 8'hFF;
    ier_cur = 8'h00; fcr_cur = 8'h00; mcr_cur = 8'h00;
    #1;
    chk("R3 ier locked ones", ier_wdata, 8'h0F);
    chk("R3 fcr locked ones", fcr_wdata, 8'hCF);
    chk("R3 mcr locked ones", mcr_wdata, 8'h1F);
    chk("R5 strobes pass", {ier_wr, fcr_wr, mcr_wr}, 3'b111);
    ier_wdata_req = 8'h00; fcr_wdata_req = 8'h00; mcr_wdata_req = 8'h00;
    ier_cur = 8'hFF; fcr_cur = 8'hFF; mcr_cur = 8'hFF;
    #1;
    chk("R3 ier locked zeros", ier_wdata, 8'hF0);
    chk("R3 fcr locked zeros", fcr_wdata, 8'h30);
    chk("R3 mcr locked zeros", mcr_wdata, 8'hE0);
    ier_wdata_req = 8'h5A; ier_cur = 8'hC3;
    #1;
    chk("R5 ier free bits", ier_wdata, 8'hCA);
    ier_wr_req = 0; fcr_wr_req = 0; mcr_wr_req = 0;
    #1;
    chk("R5 strobes idle", {ier_wr, fcr_wr, mcr_wr}, 3'b000);
  endtask

  task automatic t_unlock();
    write_efr(8'h10);
    ier_wdata_req = 8'hA5; fcr_wdata_req = 8'h96; mcr_wdata_req = 8'h3C;
    ier_cur = 8'h0F; fcr_cur = 8'hFF; mcr_cur = 8'hC3;
    #1;
    chk("R4 ier open", ier_wdata, 8'hA5);
    chk("R4 fcr open", fcr_wdata, 8'h96);
    chk("R4 mcr open", mcr_wdata, 8'h3C);
    write_efr(8'h00);
  endtask

  task automatic t_rx_nodetect();
    write_cmp(8'h13);
    send_byte(8'h13, 0);
    chk("R6 push", fifo_push, 1);
    chk("R6 data", fifo_data, 8'h13);
    chk("R8 detect off no flag", spc_flag, 0);
    step();
    chk("R6 push single", fifo_push, 0);
  endtask

  task automatic t_match();
    write_efr(8'h20);
    send_byte(8'h93, 0);
    chk("R8 top bit differs", spc_flag, 0);
    chk("R6 nonmatch stored", fifo_data, 8'h93);
    send_byte(8'h13, 0);
    chk("R7 match flag", spc_flag, 1);
    chk("R6 match stored", fifo_push && fifo_data == 8'h13, 1);
    send_byte(8'h12, 0);
    step(); step();
    chk("R9 flag sticky", spc_flag, 1);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R9 read clears", spc_flag, 0);
    send_byte(8'h13, 1);
    chk("R9 set wins over read", spc_flag, 1);
    iir_rd = 1; step(); iir_rd = 0;
    write_cmp(8'h7E);
    send_byte(8'h13, 0);
    chk("R10 old compare gone", spc_flag, 0);
    send_byte(8'h7E, 0);
    chk("R10 new compare", spc_flag, 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();
    t_reset();
    t_efr_write();
    t_lock();
    t_unlock();
    t_rx_nodetect();
    t_match();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule